// File: doc/BRIEF.md
# Mains-Synchronized Scan Trigger

This block decides the cycle in which a key-matrix scanner may begin a full pass over the matrix. It aligns that start to an external, mains-derived sync input. Each scan-start pulse releases one full matrix scan. The scanner reports the end of the scan with a single-cycle done pulse, and the block then waits for the next permitted start.

Two configuration bits choose the behaviour. With sync disabled, scans free-run: the next one starts as soon as the previous one ends. With sync enabled and sleep disabled, a falling edge on the sync input starts a scan. If no edge arrives within 100 ms of the previous scan's end, the scan starts anyway and a sticky error flag is raised. With sleep enabled, the sync input is treated as a level: a low level starts a scan, and the block waits for it with no timeout. The 100 ms window is counted as `CLK_HZ/10` clock cycles.

Top module: `mains_scan_gate`

## Requirements
- R1: With `sync_en_i` low, `scan_start_o` rises on the first clock edge after the edge that samples `scan_done_i`, whatever the sync pin does.
- R2: With sync enabled and sleep disabled, a falling edge on `sync_pin_i` while waiting gives `scan_start_o` on the third rising edge after the pin changes (two synchronizer flops plus the registered output).
- R3: In edge mode, a low level that is already present, or an edge that fell while a scan was running, does not start a scan. The fallback start comes exactly `CLK_HZ/10` edges after the edge that samples `scan_done_i`.
- R4: A fallback start caused by the timeout sets `sync_err_o` in the same cycle as the start pulse.
- R5: With sync and sleep both enabled, a low synchronized level starts a scan. While the pin is held low, every done pulse is followed by a start one edge later.
- R6: With sleep enabled there is no timeout: with the pin high, no start and no error appear however long the block waits.
- R7: After reset is released with sync enabled, `sync_err_o` is 1 after the first clock edge. In edge mode, the first scan then starts `CLK_HZ/10` edges after release.
- R8: `sync_err_o` stays 1 until `err_clr_i` is sampled high, and reads 0 one edge later. A new error condition in the same cycle as a clear wins over the clear.
- R9: `scan_start_o` is high for exactly one cycle and never rises while a scan is running (between a start and the following done).
- R10: During reset, `scan_start_o` and `sync_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, frequency given by `CLK_HZ` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_pin_i | input | 1 | Mains-derived sync signal, asynchronous |
| sync_en_i | input | 1 | 1 = align scan starts to the sync input |
| sleep_en_i | input | 1 | 1 = level-sensitive sync and no timeout |
| scan_done_i | input | 1 | Single-cycle pulse from the scanner at the end of a full scan |
| err_clr_i | input | 1 | Host pulse that clears the error flag |
| scan_start_o | output | 1 | Single-cycle pulse that releases one full matrix scan |
| sync_err_o | output | 1 | Sticky flag set when the sync is missing or overdue |

## Verification
On every cycle, the embedded assertions check the following:
- the start output is a single-cycle pulse and never rises while a scan is running;
- in free-run mode, a start always follows in the cycle after a wait begins;
- in level mode, a high synchronized pin never produces a start;
- the timeout counter stays inside its window;
- the error flag stays set until a clear and drops after one.

Only the bench's scenarios can show the exact latencies. These are the three-edge sync path, the full timeout length measured from the done pulse, and the boot-time error and first wait. They also show that edges arriving during a scan are discarded, and that a level-mode wait really is unbounded.

// File: rtl/msg_pkg.sv
package msg_pkg;
   typedef enum logic {
      GATE_WAIT = 1'b0,
      GATE_BUSY = 1'b1
   } gate_st_e;
endpackage

// File: rtl/msg_sync_chain.sv
module msg_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("msg_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q[i] <= RST_VAL;
            else         ff_q[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q[i] <= RST_VAL;
            else         ff_q[i] <= ff_q[i-1];
         end
      end
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/msg_sync_detect.sv
module msg_sync_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic s_i,
   output logic fell_o,
   output logic low_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= s_i;
   end

   assign fell_o = prev_q & ~s_i;
   assign low_o  = ~s_i;
endmodule

// File: rtl/msg_period_timer.sv
module msg_period_timer #(
   parameter int TMO_CYC = 5_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   output logic hit_o
);
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("msg_period_timer: TMO_CYC must be at least 2");
   end

   localparam int          CW   = $clog2(TMO_CYC);
   localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

   logic [CW-1:0] cnt_q;

   assign hit_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (clear_i)  cnt_q <= '0;
      else if (hit_o)    cnt_q <= '0;
      else if (run_i)    cnt_q <= cnt_q + 1'b1;
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);
endmodule

// File: rtl/mains_scan_gate.sv
module mains_scan_gate
   import msg_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_pin_i,
   input  logic sync_en_i,
   input  logic sleep_en_i,
   input  logic scan_done_i,
   input  logic err_clr_i,
   output logic scan_start_o,
   output logic sync_err_o
);
   localparam int TMO_CYC = CLK_HZ / 10;

   if (CLK_HZ < 20) begin : g_bad_clk
      $error("mains_scan_gate: CLK_HZ too small for the timeout window");
   end

   gate_st_e state_q;
   logic     pin_s, fell, low, tmo_hit, tmo_run;
   logic     trig, start_d, err_set, boot_q, start_q, err_q;

   msg_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sync_pin_i),
      .q_o   (pin_s)
   );

   msg_sync_detect u_detect (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .s_i   (pin_s),
      .fell_o(fell),
      .low_o (low)
   );

   assign tmo_run = (state_q == GATE_WAIT) && sync_en_i && !sleep_en_i;

   msg_period_timer #(.TMO_CYC(TMO_CYC)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(state_q != GATE_WAIT),
      .run_i  (tmo_run),
      .hit_o  (tmo_hit)
   );

   always_comb begin
      if (!sync_en_i)      trig = 1'b1;
      else if (sleep_en_i) trig = low;
      else                 trig = fell | tmo_hit;
   end

   assign start_d = (state_q == GATE_WAIT) && trig;
   assign err_set = (boot_q && sync_en_i) || (start_d && tmo_hit);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= GATE_WAIT;
         start_q <= 1'b0;
         err_q   <= 1'b0;
         boot_q  <= 1'b1;
      end else begin
         boot_q  <= 1'b0;
         start_q <= start_d;
         if (start_d)                                   state_q <= GATE_BUSY;
         else if (state_q == GATE_BUSY && scan_done_i)  state_q <= GATE_WAIT;
         if (err_set)        err_q <= 1'b1;
         else if (err_clr_i) err_q <= 1'b0;
      end
   end

   assign scan_start_o = start_q;
   assign sync_err_o   = err_q;

   // R9
   start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scan_start_o |=> !scan_start_o);
   // R9
   no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == GATE_BUSY && !scan_done_i) |=> !scan_start_o);
   // R1
   freerun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == GATE_WAIT && !sync_en_i) |=> scan_start_o);
   // R6
   level_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_en_i && sleep_en_i && !low) |=> !scan_start_o);
   // R8
   err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_clr_i && !err_set) |=> !sync_err_o);
   // R8
   err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_err_o && !err_clr_i) |=> sync_err_o);
endmodule

// File: tb/mains_scan_gate_tb_top.sv
module mains_scan_gate_tb_top;
   localparam int CLK_HZ = 1000;
   localparam int TMO    = CLK_HZ / 10;
   localparam int NONE   = 0;
   localparam int WIN    = 300;

   // act: 0 none, 1 drop pin 10 edges into the wait, 2 pin low before done
   typedef struct packed {
      logic       se;
      logic       sl;
      logic [1:0] act;
      logic [8:0] exp_n;
      logic       exp_err;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 2'd0, 9'd1,   1'b0},  // R1 free-run
      '{1'b0, 1'b1, 2'd2, 9'd1,   1'b0},  // R1 pin ignored
      '{1'b1, 1'b0, 2'd1, 9'd13,  1'b0},  // R2 edge
      '{1'b1, 1'b0, 2'd0, 9'd100, 1'b1},  // R3 R4 timeout
      '{1'b1, 1'b0, 2'd2, 9'd100, 1'b1},  // R3 edge during busy ignored
      '{1'b1, 1'b1, 2'd2, 9'd1,   1'b0},  // R5 level held
      '{1'b1, 1'b1, 2'd1, 9'd13,  1'b0},  // R5 level drop
      '{1'b1, 1'b1, 2'd0, 9'd0,   1'b0}   // R6 no timeout
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic pin = 1'b1, se = 1'b0, sl = 1'b0, done = 1'b0, clr = 1'b0;
   logic start, err;
   int   errors = 0, checks = 0;
   int   cyc = 0;

   always #10 clk = ~clk;

   mains_scan_gate #(.CLK_HZ(CLK_HZ)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sync_pin_i(pin), .sync_en_i(se),
      .sleep_en_i(sl), .scan_done_i(done), .err_clr_i(clr),
      .scan_start_o(start), .sync_err_o(err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_done();
      @(negedge clk); done = 1'b1;
      @(negedge clk); done = 1'b0;
   endtask

   // counts edges after the done-sampling edge until a start appears
   task automatic run_wait(input int pin_at, output int n);
      n = NONE;
      pulse_done();
      for (int k = 1; k <= WIN; k++) begin
         @(negedge clk);
         if (start) begin n = k; break; end
         if (k == pin_at) pin = 1'b0;
      end
   endtask

   task automatic prep(input logic vse, input logic vsl, input logic hold);
      pin = 1'b1; se = 1'b0; sl = 1'b0;
      pulse_done();
      for (int k = 0; k < 20; k++) begin
         if (start) break;
         @(negedge clk);
      end
      repeat (5) @(negedge clk);
      se = vse; sl = vsl; pin = hold ? 1'b0 : 1'b1;
      repeat (5) @(negedge clk);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
   endtask

   initial begin
      int n;
      int cnt;
      // R10 reset state
      se = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 start in reset", start, 0);
      chk("R10 err in reset", err, 0);
      rst_n = 1'b1;
      // R7 boot error and first wait
      @(negedge clk);
      chk("R7 err after first edge", err, 1);
      n = NONE;
      for (int k = 2; k <= WIN; k++) begin
         @(negedge clk);
         if (start) begin n = k; break; end
      end
      chk("R7 first start delay", n, TMO);

      foreach (VECS[i]) begin
         prep(VECS[i].se, VECS[i].sl, VECS[i].act == 2'd2);
         chk("R8 err cleared", err, 0);
         run_wait(VECS[i].act == 2'd1 ? 10 : -1, n);
         chk($sformatf("R1-5 row %0d latency", i), n, int'(VECS[i].exp_n));
         chk($sformatf("R4 R6 row %0d err", i), err, int'(VECS[i].exp_err));
         if (n != NONE) begin
            @(negedge clk);
            chk("R9 single cycle", start, 0);
         end
      end

      // R9 held low level: no second start while busy
      prep(1'b1, 1'b1, 1'b1);
      run_wait(-1, n);
      chk("R5 level start", n, 1);
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (start) cnt++;
      end
      chk("R9 no start while busy", cnt, 0);

      // R8 sticky error across a good scan, then clear
      prep(1'b1, 1'b0, 1'b0);
      run_wait(-1, n);
      chk("R4 timeout start", n, TMO);
      chk("R4 err set", err, 1);
      run_wait(10, n);
      chk("R2 edge start", n, 13);
      chk("R8 err sticky", err, 1);
      repeat (5) @(negedge clk);
      chk("R8 err still set", err, 1);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      chk("R8 err after clear", err, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule